// File: doc/BRIEF.md
# Dual-Bank Ping-Pong Clock-Crossing Buffer

This block carries a burst of acquisition bytes from a fast write clock to a slower reader that runs on its own clock. It holds two equal RAM banks. At any time the writer owns one bank and the reader owns the other. A bank passes to the reader only after it has been written completely. It returns to the writer only after the reader has taken every byte out of it. Because of this, no bank is ever written and read at the same time.

Ownership crosses the clock boundary as a pair of toggle signals, one in each direction, and each passes through a two-flop synchronizer. The writer flips its toggle when it hands over a full bank. The reader flips its toggle when it gives an empty bank back. If the writer fills its bank before the reader has given the other one back, the writer holds with a full flag. Any byte offered while the writer holds is thrown away, and a sticky overflow flag records the loss.

Top module: `ppbBuf`

## Requirements
- R1: After reset `rdReady`, `wrFull` and `wrOverflow` are 0 and `rdData` is 0.
- R2: The writer starts on bank 0 and the reader owns nothing. Once DEPTH bytes have been accepted, that bank passes to the reader and `rdReady` rises a few read clocks later. The reader then gets the bytes in the order they were written.
- R3: A byte offered while `wrFull` is 1 is discarded. In the next write cycle `wrOverflow` is 1, and it stays 1 until the write-side reset.
- R4: If the writer accepts the DEPTH-th byte of its bank while the reader still owns the other bank, `wrFull` is 1 in the next write cycle. `wrFull` returns to 0 once the reader releases its bank and the writer switches banks.
- R5: The read of the DEPTH-th byte of a bank, which is `rdEn` sampled high with `rdReady` high, clears `rdReady` in the same cycle that the byte appears on `rdData`. This releases the bank to the writer.
- R6: When `rdEn` is high while `rdReady` is 0, `rdData` does not change and the read address does not advance. The next bank read therefore still starts at its first byte.
- R7: While `rdReady` is 1, the bank the reader holds is never the bank the writer is filling.
- R8: When the reader keeps up, the banks alternate without loss. Every round of DEPTH bytes comes out complete and in order.
- R9: A read sampled with `rdEn` and `rdReady` both high puts its byte on `rdData` at that same read clock edge, which gives one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Acquisition (write) clock |
| wrRstN | input | 1 | Active-low asynchronous reset, write domain |
| wrEn | input | 1 | Offer one byte this write cycle |
| wrData | input | WIDTH | Byte to store |
| wrFull | output | 1 | Writer's bank is full and waiting for the other bank |
| wrOverflow | output | 1 | Sticky: a byte was dropped |
| rdClk | input | 1 | Consumer (read) clock |
| rdRstN | input | 1 | Active-low asynchronous reset, read domain |
| rdEn | input | 1 | Take one byte this read cycle |
| rdData | output | WIDTH | Last byte read |
| rdReady | output | 1 | Reader owns a full bank that still holds unread bytes |

## Verification
The bench builds the block with DEPTH=4 and WIDTH=8. With banks this short, every address wrap, every last-byte release and every bank swap happens many times in a short run, across eight rounds of arithmetically generated bytes. The two clock periods are unrelated, so the toggle handshake is exercised at shifting phase offsets. This covers the hold-and-drop case, the stall with the reader idle, and continuous streaming with the reader keeping pace.

// File: rtl/ppbPkg.sv
package ppbPkg;
  // strobe bundle from the write controller to the datapath
  typedef struct packed {
    logic write;
    logic bank;
  } wrStrobe_t;

  // strobe bundle from the read controller to the datapath
  typedef struct packed {
    logic read;
    logic bank;
  } rdStrobe_t;
endpackage

// File: rtl/ppbSync.sv
module ppbSync (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic metaQ;
  logic syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ <= 1'b0;
      syncQ <= 1'b0;
    end else begin
      metaQ <= d;
      syncQ <= metaQ;
    end
  end

  assign q = syncQ;
endmodule

// File: rtl/ppbWriteCtl.sv
module ppbWriteCtl #(
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                relToggle,
  output ppbPkg::wrStrobe_t   cmd,
  output logic [AW-1:0]       addr,
  output logic                takeToggle,
  output logic                full,
  output logic                overflow,
  output logic                bank
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addrQ;
  logic bankQ, fullQ, freeQ, togQ, ovfQ, relSeenQ;
  logic relSync, relEvent, accept, lastWr, swap;

  ppbSync u_relSync (.clk(clk), .rstN(rstN), .d(relToggle), .q(relSync));

  assign relEvent = relSync != relSeenQ;
  assign accept   = wrEn && !fullQ;
  assign lastWr   = accept && (addrQ == LAST);
  assign swap     = (lastWr || fullQ) && freeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      bankQ    <= 1'b0;
      fullQ    <= 1'b0;
      freeQ    <= 1'b1;
      togQ     <= 1'b0;
      ovfQ     <= 1'b0;
      relSeenQ <= 1'b0;
    end else begin
      relSeenQ <= relSync;
      if (relEvent) freeQ <= 1'b1;
      if (wrEn && fullQ) ovfQ <= 1'b1;
      if (accept) addrQ <= lastWr ? '0 : addrQ + 1'b1;
      if (swap) begin
        bankQ <= ~bankQ;
        togQ  <= ~togQ;
        freeQ <= 1'b0;
        fullQ <= 1'b0;
        addrQ <= '0;
      end else if (lastWr) begin
        fullQ <= 1'b1;
      end
    end
  end

  assign cmd.write  = accept;
  assign cmd.bank   = bankQ;
  assign addr       = addrQ;
  assign takeToggle = togQ;
  assign full       = fullQ;
  assign overflow   = ovfQ;
  assign bank       = bankQ;
endmodule

// File: rtl/ppbReadCtl.sv
module ppbReadCtl #(
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdEn,
  input  logic                takeToggle,
  output ppbPkg::rdStrobe_t   cmd,
  output logic [AW-1:0]       addr,
  output logic                relToggle,
  output logic                ready,
  output logic                bank
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addrQ;
  logic bankQ, readyQ, relQ, takeSeenQ;
  logic takeSync, takeEvent, fire, lastRd;

  ppbSync u_takeSync (.clk(clk), .rstN(rstN), .d(takeToggle), .q(takeSync));

  assign takeEvent = takeSync != takeSeenQ;
  assign fire      = rdEn && readyQ;
  assign lastRd    = fire && (addrQ == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      bankQ     <= 1'b1;
      readyQ    <= 1'b0;
      relQ      <= 1'b0;
      takeSeenQ <= 1'b0;
    end else begin
      takeSeenQ <= takeSync;
      if (takeEvent) begin
        readyQ <= 1'b1;
        bankQ  <= ~bankQ;
        addrQ  <= '0;
      end
      if (fire) addrQ <= lastRd ? '0 : addrQ + 1'b1;
      if (lastRd) begin
        readyQ <= 1'b0;
        relQ   <= ~relQ;
      end
    end
  end

  assign cmd.read  = fire;
  assign cmd.bank  = bankQ;
  assign addr      = addrQ;
  assign relToggle = relQ;
  assign ready     = readyQ;
  assign bank      = bankQ;
endmodule

// File: rtl/ppbDatapath.sv
module ppbDatapath #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               wrClk,
  input  ppbPkg::wrStrobe_t  wrCmd,
  input  logic [AW-1:0]      wrAddr,
  input  logic [WIDTH-1:0]   wrData,
  input  logic               rdClk,
  input  logic               rdRstN,
  input  ppbPkg::rdStrobe_t  rdCmd,
  input  logic [AW-1:0]      rdAddr,
  output logic [WIDTH-1:0]   rdData
);
  logic [WIDTH-1:0] bankOut [2];
  logic [WIDTH-1:0] rdDataQ;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WIDTH-1:0] mem [DEPTH];
    always_ff @(posedge wrClk) begin
      if (wrCmd.write && (wrCmd.bank == 1'(b))) mem[wrAddr] <= wrData;
    end
    assign bankOut[b] = mem[rdAddr];
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) rdDataQ <= '0;
    else if (rdCmd.read) rdDataQ <= bankOut[rdCmd.bank];
  end

  assign rdData = rdDataQ;
endmodule

// File: rtl/ppbBuf.sv
module ppbBuf #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 8
) (
  input  logic             wrClk,
  input  logic             wrRstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             wrFull,
  output logic             wrOverflow,
  input  logic             rdClk,
  input  logic             rdRstN,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             rdReady
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ppbPkg::wrStrobe_t wrCmd;
  ppbPkg::rdStrobe_t rdCmd;
  logic [AW-1:0] wrAddr, rdAddr;
  logic takeToggle, relToggle, wrBank, rdBank;

  ppbWriteCtl #(.DEPTH(DEPTH)) u_wrCtl (
    .clk(wrClk), .rstN(wrRstN), .wrEn(wrEn), .relToggle(relToggle),
    .cmd(wrCmd), .addr(wrAddr), .takeToggle(takeToggle),
    .full(wrFull), .overflow(wrOverflow), .bank(wrBank)
  );

  ppbReadCtl #(.DEPTH(DEPTH)) u_rdCtl (
    .clk(rdClk), .rstN(rdRstN), .rdEn(rdEn), .takeToggle(takeToggle),
    .cmd(rdCmd), .addr(rdAddr), .relToggle(relToggle),
    .ready(rdReady), .bank(rdBank)
  );

  ppbDatapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .wrClk(wrClk), .wrCmd(wrCmd), .wrAddr(wrAddr), .wrData(wrData),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdCmd(rdCmd), .rdAddr(rdAddr),
    .rdData(rdData)
  );
endmodule

// File: rtl/ppbChecker.sv
module ppbChecker #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             wrClk,
  input logic             wrRstN,
  input logic             wrEn,
  input logic             wrFull,
  input logic             wrOverflow,
  input logic             wrBank,
  input logic             rdClk,
  input logic             rdRstN,
  input logic             rdEn,
  input logic [WIDTH-1:0] rdData,
  input logic             rdReady,
  input logic             rdBank,
  input logic [AW-1:0]    rdAddr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  a_r3_drop_sets_overflow: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrFull && wrEn) |=> wrOverflow);

  a_r3_overflow_sticky: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrOverflow |=> wrOverflow);

  a_r5_last_read_releases: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdEn && rdReady && rdAddr == LAST) |=> !rdReady);

  a_r6_idle_data_hold: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdReady |=> $stable(rdData));

  a_r6_idle_addr_hold: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !(rdEn && rdReady) |=> $stable(rdAddr));

  a_r7_banks_disjoint: assert property (@(posedge wrClk) disable iff (!wrRstN || !rdRstN)
    rdReady |-> (wrBank != rdBank));
endmodule

bind ppbBuf ppbChecker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrFull(wrFull),
  .wrOverflow(wrOverflow), .wrBank(wrBank),
  .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData),
  .rdReady(rdReady), .rdBank(rdBank), .rdAddr(rdAddr)
);

// File: tb/ppbBuf_bench.sv
module ppbBuf_bench;
  localparam int DEPTH = 4;
  localparam int WIDTH = 8;
  localparam time WR_PERIOD = 25ns;
  localparam time RD_PERIOD = 37ns;

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic wrRstN = 1'b0, rdRstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic wrFull, wrOverflow, rdReady;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2) rdClk = ~rdClk;

  ppbBuf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ppbBuf (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .wrFull(wrFull), .wrOverflow(wrOverflow),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData),
    .rdReady(rdReady)
  );

  function automatic logic [WIDTH-1:0] pat(int round, int idx);
    return WIDTH'((round * 37 + idx * 11) ^ 8'h5A);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeBank(int round);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wrClk);
      wrEn = 1'b1;
      wrData = pat(round, i);
    end
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic waitReady(string tag);
    int n = 0;
    while (!rdReady && n < 200) begin
      @(negedge rdClk);
      n++;
    end
    check(tag, rdReady, 1);
  endtask

  task automatic readBank(int round, string tag);
    waitReady({tag, " ready"});
    @(negedge rdClk);
    rdEn = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge rdClk);
      check({tag, " data R9"}, rdData, pat(round, i));
      if (i == DEPTH - 1) begin
        rdEn = 1'b0;
        check("R5 ready clears on last read", rdReady, 0);
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge wrClk);
    wrRstN = 1'b1;
    rdRstN = 1'b1;
    @(negedge rdClk);
    check("R1 rdReady", rdReady, 0);
    check("R1 wrFull", wrFull, 0);
    check("R1 wrOverflow", wrOverflow, 0);
    check("R1 rdData", rdData, 0);

    // R6: reads with no bank owned
    rdEn = 1'b1;
    repeat (3) @(negedge rdClk);
    rdEn = 1'b0;
    check("R6 idle read data", rdData, 0);
    check("R6 idle read ready", rdReady, 0);

    // R2: first bank handed over
    writeBank(0);
    waitReady("R2 first bank ready");
    check("R2 no full after first bank", wrFull, 0);

    // R4/R3: second bank fills while reader idle
    writeBank(1);
    check("R4 full while other bank held", wrFull, 1);
    check("R3 no overflow yet", wrOverflow, 0);
    @(negedge wrClk);
    wrEn = 1'b1;
    wrData = 8'hEE;
    @(negedge wrClk);
    wrEn = 1'b0;
    check("R3 dropped byte sets overflow", wrOverflow, 1);

    readBank(0, "R2 bank round0");
    // R6: one read pulse right after release, before the next bank arrives
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
    check("R6 no data while not ready", rdData, pat(0, DEPTH - 1));
    readBank(1, "R6 R8 round1 starts at first byte");
    check("R4 full cleared after swap", wrFull, 0);
    check("R3 overflow sticky", wrOverflow, 1);
    check("R7 reader idle after drain", rdReady, 0);

    // R8: streaming rounds with the reader keeping up
    fork
      begin
        for (int r = 2; r < 8; r++) begin
          while (wrFull) @(negedge wrClk);
          writeBank(r);
        end
      end
      begin
        for (int r = 2; r < 8; r++) readBank(r, "R8 stream");
      end
    join

    // R1: reset clears the sticky flag
    @(negedge wrClk);
    wrRstN = 1'b0;
    rdRstN = 1'b0;
    @(negedge wrClk);
    check("R1 R3 overflow cleared by reset", wrOverflow, 0);
    check("R1 ready cleared by reset", rdReady, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule